// File: doc/BRIEF.md
# Ethernet Controller Register Front End

This block is the host-facing register layer of a descriptor-ring Ethernet controller. The host reaches every register indirectly. It first writes an 8-bit register number into a pointer port. It then reads or writes either the control/status data port or the bus-configuration data port, and the access lands on the register that the pointer selects.

The block holds the command/status word, which accepts start, stop and init commands and has write-1-to-clear event bits and a derived interrupt flag. It also holds the interrupt-mask register, the ring-size register and the mode register, plus a select register that opens a window onto a fixed table of management (PHY) registers.

Toward the rest of the controller it drives:
- receive and transmit enables;
- decoded ring lengths;
- a one-cycle request to fetch the init block;
- a one-cycle ring-rewind pulse;
- a level interrupt.

From the rest of the controller it takes:
- status events;
- an init-fetch-done pulse.

Writes take effect at the clock edge. Read data is a combinational function of the offset and the current register state.

Top module: `nic_reg_front`

## Requirements
- R1: Writing byte offset 0x14 loads the 8-bit register pointer, and a read there returns it. Offset 0x10 reaches the control/status register and offset 0x1C reaches the bus-configuration register that the pointer numbers. Any other offset, and any register number not listed in R2 to R10, reads 0, and writes to it are ignored.
- R2: A write to control register 0 with bit 2 (stop) set leaves that register reading exactly 0x0004. It clears the interrupt enable, start, init and all status bits, ignores every other bit of the same write, and pulses `ring_rewind` for the cycle after the write.
- R3: Control register 0 bits 14..8 are status bits. `stat_evt[5:0]` sets bits 14..9 and `init_done` sets bit 8. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event that arrives in the same cycle as a clear of the same bit wins.
- R4: In control register 0, writing 1 to bit 6 sets the interrupt enable, which stays set until a stop. Writing 1 to bit 0 sets init (bit 0), clears stop and pulses `init_req` for the cycle after the write. Writing 1 to bit 1 sets start (bit 1) and clears stop.
- R5: Control register 0 bit 5 and `rx_on` are 1 exactly when start is set and mode register 15 bit 0 is 0. Bit 4 and `tx_on` are 1 exactly when start is set and mode bit 1 is 0. Both follow mode-register writes.
- R6: Control register 0 bit 7 reads 1 exactly when status bits 14..8 ANDed with mask register 3 bits 14..8 are nonzero. Register 3 reads back its 16-bit value.
- R7: Register 6 holds the receive ring log2 size in bits 11:8 and the transmit ring log2 size in bits 15:12, and reads back those fields with the rest 0. Each ring length output is 2 to that power, capped at 512.
- R8: `irq` is high exactly while the interrupt flag (bit 7) and the interrupt enable (bit 6) are both set.
- R9: Configuration register 34 reads the management register chosen by configuration register 33: bits 9:5 give the PHY and bits 4:0 give the register. Writes to register 34 are ignored. PHY 0 presets are reg0=0x3100, reg1=0x786D, reg2=0x0022, reg3=0x1612, reg4=0x01E1, reg5=0x45E1 and reg31=0x8000. All other entries are 0. Register 33 reads back its 16-bit value.
- R10: Control register 88 reads 0x02623003 when `fast_sel` is 1 and 0 otherwise. Configuration register 9 always reads 1.
- R11: After reset, every register reads 0, both ring lengths are 1, and `irq`, `rx_on`, `tx_on`, `init_req` and `ring_rewind` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fast_sel | input | 1 | Selects the fast variant identity value |
| stat_evt | input | 6 | Status event pulses for bits 14..9 |
| init_done | input | 1 | Init-block fetch finished pulse |
| init_req | output | 1 | Init-block fetch request pulse |
| ring_rewind | output | 1 | Ring position reset pulse |
| rx_on | output | 1 | Receive enable |
| tx_on | output | 1 | Transmit enable |
| rx_ring_len | output | 10 | Receive ring length |
| tx_ring_len | output | 10 | Transmit ring length |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the collisions in one cycle. The first is a write-1-to-clear landing on a status bit in the same cycle that an event or `init_done` sets it. The second is a stop command carrying init, start and enable bits together. The bench drives the event pulses in the same clock as the data-port write, so each collision happens at one exact edge. A cycle-accurate behavioural model predicts the result, and it is compared on every clock against the read data, the enables, the ring lengths and both pulses. The interrupt path is exercised by moving the mask across active and inactive status bits while enable is set.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

    localparam logic [7:0] CSR_CMD   = 8'd0;
    localparam logic [7:0] CSR_IMASK = 8'd3;
    localparam logic [7:0] CSR_RLEN  = 8'd6;
    localparam logic [7:0] CSR_MODE  = 8'd15;
    localparam logic [7:0] CSR_IDENT = 8'd88;
    localparam logic [7:0] BCR_ONE   = 8'd9;
    localparam logic [7:0] BCR_MSEL  = 8'd33;
    localparam logic [7:0] BCR_MDAT  = 8'd34;

    localparam int CMD_STOP = 2;
    localparam int CMD_STRT = 1;
    localparam int CMD_INIT = 0;
    localparam int CMD_IENA = 6;

    typedef struct packed {
        logic [6:0] stat;
        logic       iena;
        logic       stop;
        logic       strt;
        logic       init;
        logic       init_req;
        logic       rewind;
    } cmd_state_t;

    typedef struct packed {
        logic [7:0]  rap;
        logic [15:0] mask;
        logic [15:0] mode;
        logic [3:0]  rx_l2;
        logic [3:0]  tx_l2;
        logic [15:0] msel;
    } front_state_t;

endpackage

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
    import nic_reg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] wdata_i,
    input  logic [1:0]  mode_i,
    input  logic [6:0]  mask_i,
    input  logic [5:0]  evt_i,
    input  logic        done_i,
    output logic [15:0] csr0_o,
    output logic        init_req_o,
    output logic        rewind_o,
    output logic        rx_on_o,
    output logic        tx_on_o,
    output logic        irq_o
);

    cmd_state_t st_d, st_q;
    logic [6:0] clr_v;
    logic       intr;

    always_comb begin
        st_d          = st_q;
        st_d.init_req = 1'b0;
        st_d.rewind   = 1'b0;
        clr_v         = wr_i ? wdata_i[14:8] : 7'd0;
        if (wr_i && wdata_i[CMD_STOP]) begin
            st_d        = '0;
            st_d.stop   = 1'b1;
            st_d.rewind = 1'b1;
        end else begin
            st_d.stat = (st_q.stat & ~clr_v) | {evt_i, done_i};
            if (wr_i && wdata_i[CMD_IENA]) begin
                st_d.iena = 1'b1;
            end
            if (wr_i && wdata_i[CMD_INIT]) begin
                st_d.init     = 1'b1;
                st_d.stop     = 1'b0;
                st_d.init_req = 1'b1;
            end
            if (wr_i && wdata_i[CMD_STRT]) begin
                st_d.strt = 1'b1;
                st_d.stop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rx_on_o    = st_q.strt & ~mode_i[0];
        tx_on_o    = st_q.strt & ~mode_i[1];
        intr       = |(st_q.stat & mask_i);
        irq_o      = intr & st_q.iena;
        init_req_o = st_q.init_req;
        rewind_o   = st_q.rewind;
        csr0_o     = {1'b0, st_q.stat, intr, st_q.iena, rx_on_o, tx_on_o,
                      1'b0, st_q.stop, st_q.strt, st_q.init};
    end

    AST_STOP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[CMD_STOP]) |=> (csr0_o == 16'h0004)); // R2

    AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.stat[0]) |-> $past(wr_i && (wdata_i[CMD_STOP] || wdata_i[8]))); // R3

    AST_IENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.iena && !(wr_i && wdata_i[CMD_STOP])) |=> st_q.iena); // R4

    AST_INIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[CMD_STOP] && wdata_i[CMD_INIT]) |=> (init_req_o && !st_q.stop)); // R4

endmodule

// File: rtl/nic_ring_len.sv
module nic_ring_len #(
    parameter int L2W    = 4,
    parameter int MAX_L2 = 9,
    localparam int LENW  = MAX_L2 + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [L2W-1:0]  l2_i,
    output logic [LENW-1:0] len_o
);

    always_comb begin
        if (l2_i >= L2W'(MAX_L2)) begin
            len_o = LENW'(1) << MAX_L2;
        end else begin
            len_o = LENW'(1) << l2_i;
        end
    end

    AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(len_o) == 1); // R7

endmodule

// File: rtl/nic_mii_rom.sv
module nic_mii_rom #(
    parameter int PHYW = 5,
    parameter int REGW = 5
) (
    input  logic [PHYW-1:0] phy_i,
    input  logic [REGW-1:0] reg_i,
    output logic [15:0]     data_o
);

    always_comb begin
        data_o = 16'h0000;
        if (phy_i == '0) begin
            case (reg_i)
                REGW'(0):  data_o = 16'h3100;
                REGW'(1):  data_o = 16'h786D;
                REGW'(2):  data_o = 16'h0022;
                REGW'(3):  data_o = 16'h1612;
                REGW'(4):  data_o = 16'h01E1;
                REGW'(5):  data_o = 16'h45E1;
                REGW'(31): data_o = 16'h8000;
                default:   data_o = 16'h0000;
            endcase
        end
    end

endmodule

// File: rtl/nic_reg_front.sv
module nic_reg_front
    import nic_reg_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         DW       = 32,
    parameter int         MAX_L2   = 9,
    parameter logic [7:0] OFF_PTR  = 8'h14,
    parameter logic [7:0] OFF_CSR  = 8'h10,
    parameter logic [7:0] OFF_BCR  = 8'h1C,
    parameter logic [31:0] FAST_ID = 32'h02623003,
    localparam int LENW = MAX_L2 + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            fast_sel,
    input  logic [5:0]      stat_evt,
    input  logic            init_done,
    output logic            init_req,
    output logic            ring_rewind,
    output logic            rx_on,
    output logic            tx_on,
    output logic [LENW-1:0] rx_ring_len,
    output logic [LENW-1:0] tx_ring_len,
    output logic            irq
);

    front_state_t fs_d, fs_q;
    logic         ptr_wr, csr_wr, bcr_wr, cmd_wr;
    logic [15:0]  csr0_val;
    logic [15:0]  mii_val;
    logic [3:0]   l2_arr [2];
    logic [LENW-1:0] len_arr [2];
    logic         unused_hi;

    assign unused_hi = ^bus_wdata[DW-1:16];

    always_comb begin
        ptr_wr = bus_wr && (bus_addr == AW'(OFF_PTR));
        csr_wr = bus_wr && (bus_addr == AW'(OFF_CSR));
        bcr_wr = bus_wr && (bus_addr == AW'(OFF_BCR));
        cmd_wr = csr_wr && (fs_q.rap == CSR_CMD);
    end

    always_comb begin
        fs_d = fs_q;
        if (ptr_wr) begin
            fs_d.rap = bus_wdata[7:0];
        end
        if (csr_wr) begin
            case (fs_q.rap)
                CSR_IMASK: fs_d.mask = bus_wdata[15:0];
                CSR_RLEN: begin
                    fs_d.rx_l2 = bus_wdata[11:8];
                    fs_d.tx_l2 = bus_wdata[15:12];
                end
                CSR_MODE:  fs_d.mode = bus_wdata[15:0];
                default: ;
            endcase
        end
        if (bcr_wr && (fs_q.rap == BCR_MSEL)) begin
            fs_d.msel = bus_wdata[15:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    nic_cmd_ctl u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cmd_wr),
        .wdata_i    (bus_wdata[15:0]),
        .mode_i     (fs_q.mode[1:0]),
        .mask_i     (fs_q.mask[14:8]),
        .evt_i      (stat_evt),
        .done_i     (init_done),
        .csr0_o     (csr0_val),
        .init_req_o (init_req),
        .rewind_o   (ring_rewind),
        .rx_on_o    (rx_on),
        .tx_on_o    (tx_on),
        .irq_o      (irq)
    );

    nic_mii_rom #(.PHYW(5), .REGW(5)) u_mii (
        .phy_i  (fs_q.msel[9:5]),
        .reg_i  (fs_q.msel[4:0]),
        .data_o (mii_val)
    );

    assign l2_arr[0] = fs_q.rx_l2;
    assign l2_arr[1] = fs_q.tx_l2;

    for (genvar g = 0; g < 2; g++) begin : g_ring
        nic_ring_len #(.L2W(4), .MAX_L2(MAX_L2)) u_len (
            .clk   (clk),
            .rst_n (rst_n),
            .l2_i  (l2_arr[g]),
            .len_o (len_arr[g])
        );
    end

    assign rx_ring_len = len_arr[0];
    assign tx_ring_len = len_arr[1];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_PTR)) begin
            bus_rdata = DW'(fs_q.rap);
        end else if (bus_addr == AW'(OFF_CSR)) begin
            case (fs_q.rap)
                CSR_CMD:   bus_rdata = DW'(csr0_val);
                CSR_IMASK: bus_rdata = DW'(fs_q.mask);
                CSR_RLEN:  bus_rdata = DW'({fs_q.tx_l2, fs_q.rx_l2, 8'h00});
                CSR_MODE:  bus_rdata = DW'(fs_q.mode);
                CSR_IDENT: bus_rdata = fast_sel ? DW'(FAST_ID) : '0;
                default:   bus_rdata = '0;
            endcase
        end else if (bus_addr == AW'(OFF_BCR)) begin
            case (fs_q.rap)
                BCR_ONE:  bus_rdata = DW'(1);
                BCR_MSEL: bus_rdata = DW'(fs_q.msel);
                BCR_MDAT: bus_rdata = DW'(mii_val);
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_MDAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bcr_wr && fs_q.rap == BCR_MDAT) |=> $stable(fs_q.msel)); // R9

    AST_ENABLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && fs_q.rap == CSR_MODE && bus_wdata[0]) |=> !rx_on); // R5

endmodule

// File: tb/nic_reg_front_tb_top.sv
module nic_reg_front_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_sel = 1'b0;
    logic [5:0]  stat_evt = '0;
    logic        init_done = 1'b0;
    logic        init_req, ring_rewind, rx_on, tx_on, irq;
    logic [9:0]  rx_ring_len, tx_ring_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_reg_front dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fast_sel(fast_sel),
        .stat_evt(stat_evt), .init_done(init_done), .init_req(init_req),
        .ring_rewind(ring_rewind), .rx_on(rx_on), .tx_on(tx_on),
        .rx_ring_len(rx_ring_len), .tx_ring_len(tx_ring_len), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    bit chk_en = 0;
    bit finished = 0;

    logic [7:0]  m_rap = 0;
    logic [6:0]  m_stat = 0;
    bit          m_iena = 0, m_stop = 0, m_strt = 0, m_init = 0;
    logic [15:0] m_mask = 0, m_mode = 0, m_sel = 0;
    logic [3:0]  m_rxl2 = 0, m_txl2 = 0;
    bit          e_init = 0, e_rew = 0;

    function automatic int ring(logic [3:0] l2);
        return (l2 >= 9) ? 512 : (1 << l2);
    endfunction

    function automatic bit m_intr();
        return (m_stat & m_mask[14:8]) != 0;
    endfunction

    function automatic logic [15:0] m_csr0();
        bit rxo = m_strt && !m_mode[0];
        bit txo = m_strt && !m_mode[1];
        return {1'b0, m_stat, m_intr(), m_iena, rxo, txo, 1'b0, m_stop, m_strt, m_init};
    endfunction

    function automatic logic [15:0] mii_exp(logic [15:0] sel);
        if (sel[9:5] != 0) return 16'h0;
        case (sel[4:0])
            5'd0:  return 16'h3100;
            5'd1:  return 16'h786D;
            5'd2:  return 16'h0022;
            5'd3:  return 16'h1612;
            5'd4:  return 16'h01E1;
            5'd5:  return 16'h45E1;
            5'd31: return 16'h8000;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_read();
        if (bus_addr == 8'h14) return {24'h0, m_rap};
        if (bus_addr == 8'h10) begin
            case (m_rap)
                8'd0:  return {16'h0, m_csr0()};
                8'd3:  return {16'h0, m_mask};
                8'd6:  return {16'h0, m_txl2, m_rxl2, 8'h00};
                8'd15: return {16'h0, m_mode};
                8'd88: return fast_sel ? 32'h02623003 : 32'h0;
                default: return 32'h0;
            endcase
        end
        if (bus_addr == 8'h1C) begin
            case (m_rap)
                8'd9:  return 32'h1;
                8'd33: return {16'h0, m_sel};
                8'd34: return {16'h0, mii_exp(m_sel)};
                default: return 32'h0;
            endcase
        end
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            check("R8 irq", {31'h0, irq}, {31'h0, m_intr() && m_iena});
            check("R5 rx_on", {31'h0, rx_on}, {31'h0, m_strt && !m_mode[0]});
            check("R5 tx_on", {31'h0, tx_on}, {31'h0, m_strt && !m_mode[1]});
            check("R7 rx_len", {22'h0, rx_ring_len}, ring(m_rxl2));
            check("R7 tx_len", {22'h0, tx_ring_len}, ring(m_txl2));
            check("R4 init_req", {31'h0, init_req}, {31'h0, e_init});
            check("R2 ring_rewind", {31'h0, ring_rewind}, {31'h0, e_rew});
            check("R1 rdata model", bus_rdata, m_read());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        e_init = 0;
        e_rew = 0;
    endtask

    task automatic model_apply(logic [7:0] a, logic [31:0] d, logic [5:0] ev, bit dn);
        bit cmd = (a == 8'h10) && (m_rap == 8'd0);
        if (cmd && d[2]) begin
            m_stat = 0; m_iena = 0; m_strt = 0; m_init = 0; m_stop = 1; e_rew = 1;
            return;
        end
        if (cmd) m_stat = m_stat & ~d[14:8];
        m_stat = m_stat | {ev, dn};
        if (cmd && d[6]) m_iena = 1;
        if (cmd && d[0]) begin m_init = 1; m_stop = 0; e_init = 1; end
        if (cmd && d[1]) begin m_strt = 1; m_stop = 0; end
        if (a == 8'h10 && m_rap == 8'd3)  m_mask = d[15:0];
        if (a == 8'h10 && m_rap == 8'd6)  begin m_rxl2 = d[11:8]; m_txl2 = d[15:12]; end
        if (a == 8'h10 && m_rap == 8'd15) m_mode = d[15:0];
        if (a == 8'h1C && m_rap == 8'd33) m_sel = d[15:0];
        if (a == 8'h14) m_rap = d[7:0];
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [5:0] ev = 0, bit dn = 0);
        bus_addr = a; bus_wdata = d; bus_wr = 1; stat_evt = ev; init_done = dn;
        tick();
        model_apply(a, d, ev, dn);
        bus_wr = 0; stat_evt = 0; init_done = 0;
    endtask

    task automatic pulse(logic [5:0] ev, bit dn);
        stat_evt = ev; init_done = dn;
        tick();
        m_stat = m_stat | {ev, dn};
        stat_evt = 0; init_done = 0;
    endtask

    task automatic rd_check(logic [7:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        @(negedge clk);
        check(tag, bus_rdata, exp);
        tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk_en = 1;
        // R11 reset state
        rd_check(8'h14, 32'h0, "R11 pointer");
        rd_check(8'h10, 32'h0, "R11 csr0");
        check("R11 rx_len", {22'h0, rx_ring_len}, 32'd1);
        check("R11 irq", {31'h0, irq}, 32'd0);
        // R1 pointer and unused offset
        bus_write(8'h14, 32'hFFFF_FF5A);
        rd_check(8'h14, 32'h5A, "R1 pointer readback");
        rd_check(8'h18, 32'h0, "R1 unused offset");
        bus_write(8'h14, 32'd40);
        bus_write(8'h10, 32'h1234);
        rd_check(8'h10, 32'h0, "R1 unimplemented register");
        // R7 ring sizes
        bus_write(8'h14, 32'd6);
        bus_write(8'h10, 32'h3500);
        rd_check(8'h10, 32'h3500, "R7 csr6 readback");
        check("R7 rx 32", {22'h0, rx_ring_len}, 32'd32);
        check("R7 tx 8", {22'h0, tx_ring_len}, 32'd8);
        bus_write(8'h10, 32'hF9FF);
        rd_check(8'h10, 32'hF900, "R7 csr6 fields only");
        check("R7 cap rx", {22'h0, rx_ring_len}, 32'd512);
        check("R7 cap tx", {22'h0, tx_ring_len}, 32'd512);
        // R5 enables from mode
        bus_write(8'h14, 32'd15);
        bus_write(8'h10, 32'h0001);
        bus_write(8'h14, 32'd0);
        bus_write(8'h10, 32'h0042);
        rd_check(8'h10, 32'h0052, "R5 rx disabled by mode");
        bus_write(8'h14, 32'd15);
        bus_write(8'h10, 32'h0002);
        check("R5 tx off by mode", {31'h0, tx_on}, 32'd0);
        check("R5 rx on", {31'h0, rx_on}, 32'd1);
        bus_write(8'h10, 32'h0000);
        bus_write(8'h14, 32'd0);
        rd_check(8'h10, 32'h0072, "R5 both on");
        // R4 init request, R6 mask, R8 irq
        bus_write(8'h10, 32'h0001);
        pulse(6'h00, 1'b1);
        rd_check(8'h10, 32'h0173, "R4 init done status");
        bus_write(8'h14, 32'd3);
        bus_write(8'h10, 32'h0100);
        rd_check(8'h10, 32'h0100, "R6 mask readback");
        check("R8 irq raised", {31'h0, irq}, 32'd1);
        bus_write(8'h14, 32'd0);
        rd_check(8'h10, 32'h01F3, "R6 flag set");
        // R3 write-1-to-clear
        bus_write(8'h10, 32'h0000);
        rd_check(8'h10, 32'h01F3, "R3 zero write keeps");
        bus_write(8'h10, 32'h0100);
        rd_check(8'h10, 32'h0073, "R3 clear idon");
        check("R8 irq dropped", {31'h0, irq}, 32'd0);
        pulse(6'h03, 1'b0);
        rd_check(8'h10, 32'h0673, "R3 events set");
        bus_write(8'h14, 32'd3);
        bus_write(8'h10, 32'h0400);
        bus_write(8'h14, 32'd0);
        rd_check(8'h10, 32'h06F3, "R6 mask on rx event");
        bus_write(8'h10, 32'h0300, 6'h01, 1'b1);
        rd_check(8'h10, 32'h07F3, "R3 set wins over clear");
        // R2 stop priority
        bus_write(8'h10, 32'h0047);
        rd_check(8'h10, 32'h0004, "R2 stop exact");
        check("R2 irq off", {31'h0, irq}, 32'd0);
        bus_write(8'h10, 32'h0002);
        rd_check(8'h10, 32'h0032, "R4 start clears stop");
        // R9 management window
        bus_write(8'h14, 32'd33);
        bus_write(8'h1C, 32'h0001);
        bus_write(8'h14, 32'd34);
        rd_check(8'h1C, 32'h786D, "R9 phy0 reg1");
        bus_write(8'h1C, 32'hFFFF);
        rd_check(8'h1C, 32'h786D, "R9 write ignored");
        bus_write(8'h14, 32'd33);
        rd_check(8'h1C, 32'h0001, "R9 select unchanged");
        bus_write(8'h1C, 32'h0021);
        bus_write(8'h14, 32'd34);
        rd_check(8'h1C, 32'h0000, "R9 other phy");
        bus_write(8'h14, 32'd33);
        bus_write(8'h1C, 32'h001F);
        bus_write(8'h14, 32'd34);
        rd_check(8'h1C, 32'h8000, "R9 phy0 reg31");
        // R10 identity and constant
        bus_write(8'h14, 32'd88);
        rd_check(8'h10, 32'h0, "R10 slow id");
        fast_sel = 1;
        rd_check(8'h10, 32'h02623003, "R10 fast id");
        bus_write(8'h14, 32'd9);
        rd_check(8'h1C, 32'h1, "R10 bcr9");
        repeat (2) tick();
        finished = 1;
        summary();
        $finish;
    end

endmodule